// File: doc/BRIEF.md
# Lane-Synchronous Coalescing Shift Queue

This block buffers memory requests from several lanes in rows that all lanes share. Each accepted enqueue fills one whole row. A lane that offers nothing in that cycle leaves an empty slot in the row. The oldest row sits at the head, and each lane presents its own head slot on its own dequeue port.

A neighbouring merge stage can claim head entries by raising the lane's coalescable flag, which hides the entry from the dequeue port. The merge stage can also remove chosen slots in any row through an invalidate bitmask, without dequeuing them. Once no valid slot remains in the head row, the queue shifts by one row at the next clock edge. When every row is occupied, enqueue is held off.

Top module: `coal_shift_queue`

## Requirements
- R1: When any lane's enqueue valid is accepted, the queue takes exactly one row at that edge. A lane whose enqueue valid is low leaves its slot in that row empty, so that slot is never offered for dequeue.
- R2: Lane l's dequeue valid is high only when its head slot holds a valid entry and coalescable[l] is low. Its dequeue data is the head slot's payload.
- R3: While every coalescable input is high, no dequeue valid is raised and no entry is lost, even with every dequeue ready high.
- R4: A lane's head entry leaves on its own edge, when dequeue valid and ready are both high. The other valid slots of the head row stay offered.
- R5: When no valid slot would remain in the head row after an edge, the queue shifts at that edge, and the next row's entries are offered in the following cycle.
- R6: Enqueue ready, which is common to all lanes, is low exactly when all DEPTH rows are occupied. A dequeue that empties the head row brings it back high in the next cycle.
- R7: Enqueue and a shifting dequeue can take place at the same edge, so rows stream through at one row per cycle without a bubble.
- R8: When inv_valid is high, each slot whose bit inv_mask[l*DEPTH+d] is set is cleared at the edge, for lane l and row d with row 0 at the head. A head row left with no valid slot shifts out without any dequeue.
- R9: After reset, no row is occupied, all dequeue valids are low and enqueue ready is high.
- R10: Within each lane, entries leave in the order they were enqueued, less any invalidated ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | LANES | Per-lane enqueue request |
| enq_data | input | LANES*W | Per-lane payload; lane l in bits [l*W +: W] |
| enq_ready | output | LANES | Room for another row (the same value on every lane) |
| deq_valid | output | LANES | Head slot offered on this lane |
| deq_data | output | LANES*W | Head slot payload per lane |
| deq_ready | input | LANES | Consumer accepts the lane's head |
| coalescable | input | LANES | Lane's head is claimed by the merge stage |
| inv_valid | input | 1 | Apply the invalidate mask this cycle |
| inv_mask | input | LANES*DEPTH | Slot clear bits; bit l*DEPTH+d is lane l, row d |

## Verification
Dequeue valid and data follow the head state and the coalescable flags in the same cycle. The bench therefore checks them after the inputs settle, before the next edge. A dequeue, an invalidation, a shift or an enqueue takes effect at the next edge. Its result, including the change in enqueue ready, is checked one cycle after the stimulus. The scoreboard pops an expected payload only in a cycle where the lane's valid and ready are both high at the sampling point, so each pop matches exactly one retiring edge.

// File: rtl/csq_pkg.sv
package csq_pkg;
  parameter int unsigned CSQ_LANES = 4;
  parameter int unsigned CSQ_DEPTH = 4;
  parameter int unsigned CSQ_W     = 8;

  function automatic int unsigned csq_clog2(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/csq_occupancy.sv
module csq_occupancy #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = csq_pkg::csq_clog2(DEPTH + 1),
  localparam int unsigned RW = csq_pkg::csq_clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_enq,
  input  logic          head_keep_any,
  output logic          room,
  output logic          push,
  output logic          shift,
  output logic [RW-1:0] wr_row
);
  logic [CW-1:0] count_q, count_d;
  logic          count_en;
  logic [CW-1:0] base;

  always_comb begin
    room     = (count_q < CW'(DEPTH));
    push     = room && any_enq;
    shift    = (count_q != '0) && !head_keep_any;
    base     = count_q - (shift ? CW'(1) : CW'(0));
    wr_row   = RW'(base);
    count_en = push || shift;
    count_d  = base + (push ? CW'(1) : CW'(0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assert_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  assert_shift_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !push) |=> (count_q == $past(count_q) - CW'(1)));

  assert_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && push) |=> $stable(count_q));
endmodule

// File: rtl/csq_lane.sv
module csq_lane #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8,
  localparam int unsigned RW = csq_pkg::csq_clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             push,
  input  logic [RW-1:0]    wr_row,
  input  logic             enq_valid,
  input  logic [W-1:0]     enq_data,
  input  logic             inv_valid,
  input  logic [DEPTH-1:0] inv_row,
  input  logic             coal,
  input  logic             deq_ready,
  output logic             deq_valid,
  output logic [W-1:0]     deq_data,
  output logic             head_keep
);
  logic [DEPTH-1:0] vld_q, vld_d, vld_mid;
  logic [W-1:0]     dat_q [DEPTH];
  logic [W-1:0]     dat_d [DEPTH];
  logic [DEPTH-1:0] dat_en;
  logic             fire;

  always_comb begin
    deq_valid = vld_q[0] && !coal;
    deq_data  = dat_q[0];
    fire      = deq_valid && deq_ready;
    for (int d = 0; d < DEPTH; d++) begin
      vld_mid[d] = vld_q[d] && !(inv_valid && inv_row[d]) && !((d == 0) && fire);
    end
    head_keep = vld_mid[0];
  end

  for (genvar d = 0; d < DEPTH; d++) begin : g_slot
    logic wr_here;
    logic up_v;
    logic [W-1:0] up_dat;
    if (d < DEPTH - 1) begin : g_mid
      assign up_v   = vld_mid[d+1];
      assign up_dat = dat_q[d+1];
    end else begin : g_top
      assign up_v   = 1'b0;
      assign up_dat = dat_q[d];
    end
    assign wr_here = push && (wr_row == RW'(d));

    always_comb begin
      vld_d[d] = shift ? up_v : vld_mid[d];
      dat_d[d] = shift ? up_dat : dat_q[d];
      dat_en[d] = shift;
      if (wr_here) begin
        vld_d[d] = enq_valid;
        if (enq_valid) begin
          dat_d[d]  = enq_data;
          dat_en[d] = 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dat_q[d] <= '0;
      else if (dat_en[d]) dat_q[d] <= dat_d[d];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assert_fire_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !shift) |=> !vld_q[0]);

  assert_claimed_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q[0] && coal && !(inv_valid && inv_row[0])) |=> vld_q[0]);
endmodule

// File: rtl/coal_shift_queue.sv
module coal_shift_queue #(
  parameter int unsigned LANES = csq_pkg::CSQ_LANES,
  parameter int unsigned DEPTH = csq_pkg::CSQ_DEPTH,
  parameter int unsigned W     = csq_pkg::CSQ_W,
  localparam int unsigned RW = csq_pkg::csq_clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       enq_valid,
  input  logic [LANES*W-1:0]     enq_data,
  output logic [LANES-1:0]       enq_ready,
  output logic [LANES-1:0]       deq_valid,
  output logic [LANES*W-1:0]     deq_data,
  input  logic [LANES-1:0]       deq_ready,
  input  logic [LANES-1:0]       coalescable,
  input  logic                   inv_valid,
  input  logic [LANES*DEPTH-1:0] inv_mask
);
  logic [LANES-1:0] head_keep;
  logic             room, push, shift;
  logic [RW-1:0]    wr_row;

  csq_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n),
    .any_enq(|enq_valid), .head_keep_any(|head_keep),
    .room(room), .push(push), .shift(shift), .wr_row(wr_row)
  );

  assign enq_ready = {LANES{room}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    csq_lane #(.DEPTH(DEPTH), .W(W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .shift(shift), .push(push), .wr_row(wr_row),
      .enq_valid(enq_valid[l]), .enq_data(enq_data[l*W +: W]),
      .inv_valid(inv_valid), .inv_row(inv_mask[l*DEPTH +: DEPTH]),
      .coal(coalescable[l]), .deq_ready(deq_ready[l]),
      .deq_valid(deq_valid[l]), .deq_data(deq_data[l*W +: W]),
      .head_keep(head_keep[l])
    );
  end

  assert_claimed_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&coalescable) |-> (deq_valid == '0));

  assert_full_backpressure_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!room && !shift) |=> !room);
endmodule

// File: tb/tb_coal_shift_queue.sv
module tb_coal_shift_queue;
  localparam int L = 4;
  localparam int D = 4;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [L-1:0]   enq_valid, enq_ready, deq_valid, deq_ready, coalescable;
  logic [L*W-1:0] enq_data, deq_data;
  logic           inv_valid;
  logic [L*D-1:0] inv_mask;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;
  logic [W-1:0] expq [L][$];

  always #5 clk = ~clk;

  coal_shift_queue #(.LANES(L), .DEPTH(D), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_data(enq_data),
    .enq_ready(enq_ready), .deq_valid(deq_valid), .deq_data(deq_data),
    .deq_ready(deq_ready), .coalescable(coalescable),
    .inv_valid(inv_valid), .inv_mask(inv_mask)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // driver: offers a row for one cycle and records accepted items
  task automatic drive_row(input logic [L-1:0] v, input logic [W-1:0] base);
    enq_valid = v;
    for (int l = 0; l < L; l++) enq_data[l*W +: W] = base + W'(l);
    #1;
    if (enq_ready[0])
      for (int l = 0; l < L; l++) if (v[l]) expq[l].push_back(base + W'(l));
    step();
    enq_valid = '0;
  endtask

  // monitor: compares each retiring head against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < L; l++) begin
        if (deq_valid[l] && deq_ready[l]) begin
          if (expq[l].size() == 0) begin
            chk(1'b0, "R10 unexpected dequeue", 32'(deq_data[l*W +: W]), 32'hFFFF);
          end else begin
            logic [W-1:0] e;
            e = expq[l].pop_front();
            chk(deq_data[l*W +: W] == e, "R10 order/data", 32'(deq_data[l*W +: W]), 32'(e));
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enq_valid = '0; enq_data = '0; deq_ready = '0;
    coalescable = '0; inv_valid = 1'b0; inv_mask = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R9
    chk(enq_ready == '1, "R9 enq_ready", 32'(enq_ready), 32'hF);
    chk(deq_valid == '0, "R9 deq_valid", 32'(deq_valid), 32'h0);

    // R3 all claimed: three rows, nothing offered
    coalescable = '1; deq_ready = '1;
    drive_row(4'b1111, 8'h10);
    drive_row(4'b0001, 8'h20);
    drive_row(4'b1111, 8'h30);
    #1;
    chk(deq_valid == '0, "R3 claimed hidden", 32'(deq_valid), 32'h0);
    step(); #1;
    chk(deq_valid == '0, "R3 still held", 32'(deq_valid), 32'h0);

    // R2 per-lane gating
    coalescable = 4'b1000; deq_ready = 4'b1001; #1;
    chk(deq_valid == 4'b0111, "R2 gated valid", 32'(deq_valid), 32'h7);
    step();
    coalescable = '0; deq_ready = '0; #1;
    chk(deq_valid == 4'b1110, "R4 lane0 retired alone", 32'(deq_valid), 32'hE);
    deq_ready = '1;
    step(); #1;
    chk(deq_valid == 4'b0001, "R1/R5 sparse row at head", 32'(deq_valid), 32'h1);
    step(); #1;
    chk(deq_valid == 4'b1111, "R5 next row", 32'(deq_valid), 32'hF);
    step(); #1;
    chk(deq_valid == '0, "R5 empty after drain", 32'(deq_valid), 32'h0);

    // R6 full back-pressure
    coalescable = '1;
    for (int r = 0; r < D; r++) drive_row(4'b1111, 8'h40 + 8'(r * 16));
    #1;
    chk(enq_ready == '0, "R6 full", 32'(enq_ready), 32'h0);
    coalescable = '0;
    step(); #1;
    chk(enq_ready == '1, "R6 freed", 32'(enq_ready), 32'hF);

    // R7 streaming
    for (int r = 0; r < 5; r++) begin
      #1;
      chk(deq_valid == '1, "R7 stream valid", 32'(deq_valid), 32'hF);
      drive_row(4'b1111, 8'h90 + 8'(r * 8));
    end
    repeat (3) step();
    #1;
    chk(deq_valid == '0, "R7 drained", 32'(deq_valid), 32'h0);

    // R8 invalidate: whole head row plus lane2 of row 1
    deq_ready = '0;
    drive_row(4'b1111, 8'hC0);
    drive_row(4'b1111, 8'hD0);
    inv_valid = 1'b1;
    inv_mask  = '0;
    for (int l = 0; l < L; l++) inv_mask[l*D + 0] = 1'b1;
    inv_mask[2*D + 1] = 1'b1;
    for (int l = 0; l < L; l++) void'(expq[l].pop_front());
    void'(expq[2].pop_front());
    step();
    inv_valid = 1'b0; inv_mask = '0; #1;
    chk(deq_valid == 4'b1011, "R8 cleared row shifted", 32'(deq_valid), 32'hB);
    deq_ready = '1;
    step(); #1;
    chk(deq_valid == '0, "R8 empty", 32'(deq_valid), 32'h0);
    chk(enq_ready == '1, "R8 room", 32'(enq_ready), 32'hF);

    for (int l = 0; l < L; l++)
      chk(expq[l].size() == 0, "R10 scoreboard empty", 32'(expq[l].size()), 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule